// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the state machine at the centre of an on-chip debug trigger. Three comparator channels elsewhere in the chip each send it a one-cycle match pulse and an enable bit. While the debug logic is armed, the sequencer walks through the non-final states State1, State2 and State3 toward a terminal Final state. In every non-final state, a 4-bit control code chosen by software decides two things: which match channels cause a move, and where each move goes. When the sequencer reaches Final, it raises a flag that downstream trigger logic acts on.

The three control codes sit behind one register address. A 2-bit bank select picks which of them that address reaches. Software can change a code only while the sequencer is disarmed. If several enabled matches arrive in the same cycle, a fixed rule picks one of them.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset the state output is 0 (Idle), the final flag is low, and all three control codes are 0.
- R2: The control window is at address 0x27. Bank select 00 reaches the State1 code, 01 the State2 code and 10 the State3 code. A read returns the addressed code in bits 3:0 with bits 7:4 always zero. A read with bank select 11, or at any other address, returns 0.
- R3: A write changes a code only when it targets address 0x27 with bank select 00, 01 or 10 while arm is low. Any other write, including every write made while arm is high, leaves all codes unchanged.
- R4: On the first edge with arm high, Idle moves to State1 (state output 1). On any edge with arm low, the state returns to Idle (0). The other state encodings are State2=2, State3=3 and Final=4.
- R5: Each code gives every channel one target: none, slot A, slot B or Final. The targets are listed as (channel0, channel1, channel2). 0:(F,F,B) 1:(F,F,A) 2:(F,none,A) 3:(F,B,none) 4:(A,none,B) 5:(none,A,B) 6:(F,F,none) 7:(none,none,F) 8:(none,B,none) 9:(none,none,B).
- R6: Slot A and slot B depend on the current state. In State1, A is State2 and B is State3. In State2, A is State1 and B is State3. In State3, A is State1 and B is State2.
- R7: A match pulse counts only in a cycle where that channel's enable bit is high.
- R8: If any counted match in a cycle targets Final, the next state is Final.
- R9: Otherwise the counted match with the lowest channel number that has a target decides the next state.
- R10: A counted match with no target in the current code has no effect. Codes 10 to 15 are reserved and give no transitions, so the state is held.
- R11: Final is held while arm stays high, whatever matches arrive. The final flag is high exactly when the state is Final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Debug armed level |
| bank_sel_i | input | 2 | Bank select for the control window |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data (bits 3:0 used) |
| rd_data_o | output | 8 | Read data, combinational |
| match_i | input | 3 | Match pulses from channels 0..2 |
| match_en_i | input | 3 | Per-channel comparator enables |
| state_o | output | 3 | Current state encoding |
| final_o | output | 1 | Final state reached |

## Verification
The embedded assertions check, on every cycle, the cycle-level rules: the Idle/State1 handoff on arming, the return to Idle on disarming, the hold in Final, the frozen codes while armed, the zero upper read bits, the hold under reserved codes, and the win of a Final-bound match. Only the bench scenarios can show that every code and slot mapping is right, and that the lowest channel wins among non-final moves. The bench does this by comparing each transition with an independent model. This happens across directed walks through all three states and a long random run over codes, enables and arm toggles.

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 'h27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [1:0]        bank_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  input  logic [2:0]        match_i,
  input  logic [2:0]        match_en_i,
  output logic [2:0]        state_o,
  output logic              final_o
);

  localparam logic [2:0] ST_IDLE = 3'd0, ST_S1 = 3'd1, ST_S2 = 3'd2, ST_S3 = 3'd3, ST_FIN = 3'd4;
  localparam logic [1:0] T_NONE = 2'd0, T_A = 2'd1, T_B = 2'd2, T_FIN = 2'd3;

  logic [3:0] ctl1_q, ctl2_q, ctl3_q;
  logic [2:0] st_q, st_d;

  // per-code targets packed as {ch2, ch1, ch0}
  function automatic logic [5:0] code_map(input logic [3:0] c);
    case (c)
      4'd0:    code_map = {T_B,    T_FIN,  T_FIN};
      4'd1:    code_map = {T_A,    T_FIN,  T_FIN};
      4'd2:    code_map = {T_A,    T_NONE, T_FIN};
      4'd3:    code_map = {T_NONE, T_B,    T_FIN};
      4'd4:    code_map = {T_B,    T_NONE, T_A};
      4'd5:    code_map = {T_B,    T_A,    T_NONE};
      4'd6:    code_map = {T_NONE, T_FIN,  T_FIN};
      4'd7:    code_map = {T_FIN,  T_NONE, T_NONE};
      4'd8:    code_map = {T_NONE, T_B,    T_NONE};
      4'd9:    code_map = {T_B,    T_NONE, T_NONE};
      default: code_map = 6'd0;
    endcase
  endfunction

  wire win_hit = (addr_i == CTL_ADDR) && (bank_sel_i != 2'b11);
  wire wr_ok   = wr_en_i && win_hit && !arm_i;
  wire active  = arm_i && (st_q == ST_S1 || st_q == ST_S2 || st_q == ST_S3);

  wire [3:0] cur_code = (st_q == ST_S1) ? ctl1_q : (st_q == ST_S2) ? ctl2_q : ctl3_q;
  wire [5:0] tmap     = code_map(cur_code);
  wire [2:0] hit      = match_i & match_en_i;
  wire [1:0] t0 = hit[0] ? tmap[1:0] : T_NONE;
  wire [1:0] t1 = hit[1] ? tmap[3:2] : T_NONE;
  wire [1:0] t2 = hit[2] ? tmap[5:4] : T_NONE;
  wire fin_hit  = (t0 == T_FIN) || (t1 == T_FIN) || (t2 == T_FIN);
  wire [1:0] pick = fin_hit ? T_FIN : (t0 != T_NONE) ? t0 : (t1 != T_NONE) ? t1 : t2;

  wire [2:0] slot_a = (st_q == ST_S1) ? ST_S2 : ST_S1;
  wire [2:0] slot_b = (st_q == ST_S3) ? ST_S2 : ST_S3;

  always_comb begin
    st_d = st_q;
    if (!arm_i) st_d = ST_IDLE;
    else if (st_q == ST_IDLE) st_d = ST_S1;
    else if (active) begin
      case (pick)
        T_FIN:   st_d = ST_FIN;
        T_A:     st_d = slot_a;
        T_B:     st_d = slot_b;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ctl1_q <= '0;
      ctl2_q <= '0;
      ctl3_q <= '0;
    end else begin
      st_q <= st_d;
      if (wr_ok) begin
        case (bank_sel_i)
          2'b00:   ctl1_q <= wr_data_i[3:0];
          2'b01:   ctl2_q <= wr_data_i[3:0];
          default: ctl3_q <= wr_data_i[3:0];
        endcase
      end
    end
  end

  assign rd_data_o = !win_hit ? 8'h00 :
                     {4'h0, (bank_sel_i == 2'b00) ? ctl1_q : (bank_sel_i == 2'b01) ? ctl2_q : ctl3_q};
  assign state_o = st_q;
  assign final_o = (st_q == ST_FIN);

  p_rd_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) rd_data_o[7:4] == 4'h0);
  p_wr_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> ($stable(ctl1_q) && $stable(ctl2_q) && $stable(ctl3_q)));
  p_arm_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && state_o == ST_IDLE) |=> state_o == ST_S1);
  p_disarm_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> state_o == ST_IDLE);
  p_no_enable_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && (match_i & match_en_i) == 3'b000) |=> $stable(state_o));
  p_final_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && fin_hit) |=> final_o);
  p_reserved_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && cur_code >= 4'd10) |=> $stable(state_o));
  p_final_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (final_o && arm_i) |=> final_o);
  p_legal_state_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o <= ST_FIN) && (final_o == (state_o == ST_FIN)));

endmodule

// File: tb/test_dbg_trig_seq.sv
module test_dbg_trig_seq;
  logic clk = 0, rst_n = 0, arm = 0, wr = 0;
  logic [1:0] bank = 0;
  logic [7:0] addr = 0, wdat = 0;
  logic [2:0] m = 0, en = 0;
  logic [7:0] rdat;
  logic [2:0] st;
  logic fin;
  int checks = 0, errors = 0;
  logic [2:0] m_st = 0;
  logic [3:0] c1 = 0, c2 = 0, c3 = 0;

  always #4 clk = ~clk;

  dbg_trig_seq i_dbg_trig_seq (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .bank_sel_i(bank), .addr_i(addr),
    .wr_en_i(wr), .wr_data_i(wdat), .rd_data_o(rdat), .match_i(m), .match_en_i(en),
    .state_o(st), .final_o(fin));

  function automatic int b_tgt(input logic [3:0] c, input int ch);
    case (c)
      0: return ch == 2 ? 2 : 3;
      1: return ch == 2 ? 1 : 3;
      2: return ch == 0 ? 3 : (ch == 2 ? 1 : 0);
      3: return ch == 0 ? 3 : (ch == 1 ? 2 : 0);
      4: return ch == 0 ? 1 : (ch == 2 ? 2 : 0);
      5: return ch == 1 ? 1 : (ch == 2 ? 2 : 0);
      6: return ch == 2 ? 0 : 3;
      7: return ch == 2 ? 3 : 0;
      8: return ch == 1 ? 2 : 0;
      9: return ch == 2 ? 2 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] b_next(input logic [2:0] s, input logic a, input logic [2:0] mm,
                                        input logic [2:0] ee);
    logic [3:0] code;
    logic [2:0] best;
    logic f;
    if (!a) return 3'd0;
    if (s == 0) return 3'd1;
    if (s == 4) return 3'd4;
    code = (s == 1) ? c1 : (s == 2) ? c2 : c3;
    best = 0; f = 0;
    for (int ch = 0; ch < 3; ch++) begin
      if (mm[ch] && ee[ch]) begin
        int t = b_tgt(code, ch);
        if (t == 3) f = 1;
        else if (t == 1 && best == 0) best = (s == 1) ? 3'd2 : 3'd1;
        else if (t == 2 && best == 0) best = (s == 3) ? 3'd2 : 3'd3;
      end
    end
    if (f) return 3'd4;
    return (best == 0) ? s : best;
  endfunction

  function automatic logic [7:0] b_read(input logic [1:0] b, input logic [7:0] ad);
    if (ad != 8'h27 || b == 2'b11) return 8'h00;
    return {4'h0, b == 0 ? c1 : (b == 1 ? c2 : c3)};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // inputs are set after a negedge; one clock edge; compare after next negedge
  task automatic tick(input string tag);
    logic [2:0] nx = b_next(m_st, arm, m, en);
    if (wr && addr == 8'h27 && bank != 2'b11 && !arm) begin
      if (bank == 0) c1 = wdat[3:0];
      else if (bank == 1) c2 = wdat[3:0];
      else c3 = wdat[3:0];
    end
    m_st = nx;
    @(negedge clk);
    chk({5'd0, st}, {5'd0, m_st}, tag);
    chk({7'd0, fin}, {7'd0, m_st == 3'd4}, tag);
    wr = 0; m = 0;
  endtask

  task automatic wreg(input logic [1:0] b, input logic [7:0] d, input string tag);
    wr = 1; bank = b; addr = 8'h27; wdat = d;
    tick(tag);
  endtask

  task automatic rreg(input logic [1:0] b, input logic [7:0] ad, input logic [7:0] exp, input string tag);
    bank = b; addr = ad; #1;
    chk(rdat, exp, tag);
    chk(rdat, b_read(b, ad), tag);
  endtask

  task automatic go(input logic [2:0] mm, input logic [2:0] ee, input logic [2:0] exp, input string tag);
    m = mm; en = ee;
    tick(tag);
    chk({5'd0, st}, {5'd0, exp}, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({5'd0, st}, 8'd0, "R1 state");
    chk({7'd0, fin}, 8'd0, "R1 final");
    rreg(0, 8'h27, 8'h00, "R1 ctl1");
    rreg(1, 8'h27, 8'h00, "R1 ctl2");
    rreg(2, 8'h27, 8'h00, "R1 ctl3");
    rst_n = 1;
    @(negedge clk);

    wreg(1, 8'h5A, "R2 write");
    rreg(1, 8'h27, 8'h0A, "R2 upper bits zero");
    wreg(3, 8'h03, "R3 bank11 write");
    rreg(3, 8'h27, 8'h00, "R2 bank11 read");
    wr = 1; bank = 0; addr = 8'h26; wdat = 8'h07; tick("R3 other addr");
    rreg(0, 8'h27, 8'h00, "R3 other addr ignored");
    rreg(1, 8'h28, 8'h00, "R2 other addr read");

    // Phase A
    wreg(0, 4, "R3 setup"); wreg(1, 0, "R3 setup"); wreg(2, 9, "R3 setup");
    arm = 1; go(0, 0, 1, "R4 arm to State1");
    go(3'b001, 3'b111, 2, "R6 State1 slot A");
    go(3'b110, 3'b111, 4, "R8 final wins");
    chk({7'd0, fin}, 8'd1, "R11 flag");
    go(3'b111, 3'b111, 4, "R11 sticky");
    arm = 0; go(0, 0, 0, "R4 disarm");
    // Phase B
    arm = 1; go(0, 0, 1, "R4 arm");
    go(3'b100, 3'b111, 3, "R6 State1 slot B");
    go(3'b100, 3'b111, 2, "R6 State3 slot B");
    go(3'b001, 3'b110, 2, "R7 disabled channel");
    wreg(1, 8'h07, "R3 armed write");
    rreg(1, 8'h27, 8'h00, "R3 locked while armed");
    arm = 0; go(0, 0, 0, "R4 disarm");
    // Phase C
    wreg(1, 4, "R3 setup"); wreg(0, 9, "R3 setup"); wreg(2, 12, "R3 setup");
    arm = 1; go(0, 0, 1, "R4 arm");
    go(3'b100, 3'b111, 3, "R6 State1 slot B");
    go(3'b111, 3'b111, 3, "R10 reserved code");
    arm = 0; go(0, 0, 0, "R4 disarm");
    // Phase D
    wreg(0, 4, "R3 setup");
    arm = 1; go(0, 0, 1, "R4 arm");
    go(3'b001, 3'b111, 2, "R6 to State2");
    go(3'b101, 3'b111, 1, "R9 lowest channel");
    arm = 0; go(0, 0, 0, "R4 disarm");
    // Phase E
    wreg(1, 7, "R3 setup");
    arm = 1; go(0, 0, 1, "R4 arm");
    go(3'b001, 3'b111, 2, "R6 to State2");
    go(3'b011, 3'b111, 2, "R10 unlisted match");
    go(3'b100, 3'b111, 4, "R5 code 7 final");
    arm = 0; go(0, 0, 0, "R4 disarm");

    // random
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) arm = ~arm;
      m = 3'($urandom); en = 3'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        wr = 1; bank = 2'($urandom); wdat = 8'($urandom_range(0, 15));
        addr = ($urandom_range(0, 7) == 0) ? 8'h26 : 8'h27;
      end
      tick("R5/R8/R9 random");
      bank = 2'($urandom); addr = ($urandom_range(0, 5) == 0) ? 8'h30 : 8'h27; #1;
      chk(rdat, b_read(bank, addr), "R2 random read");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule